// File: doc/BRIEF.md
# Receive Character Match Gate

This block sits after a serial receiver and screens each received character against two programmed compare values. Every character gets a match decision. The two values form an inclusive window when the low value does not exceed the high value. Otherwise the character must equal one of the two values exactly. A match sets a sticky flag. That flag, ANDed with a software-controlled enable, drives an interrupt line.

The block has two operating modes, chosen by `gate_mode`.

- **Flag mode (`gate_mode` = 0):** every received character is forwarded, and a match only updates the flag.
- **Hold mode (`gate_mode` = 1):** characters are dropped until one matches. That character and every later one are forwarded until software writes the clear-trigger command.

The gate is a two-state machine:

- **GATE_SHUT**, the reset state. It moves to GATE_PASS on the transition *trigger*: a matching character arrives while hold mode is selected.
- **GATE_PASS**. It returns to GATE_SHUT on the transition *release*: a control write with the clear bit set.
- If a release and a trigger fall in the same cycle, the trigger wins and the gate stays in GATE_PASS.

All outputs are registered. A character presented on one clock edge appears on the forward port, and updates the flag, at the next edge.

Top module: `rx_match_gate`

## Requirements
- R1: The compare word holds the low value in bits 15:0 and the high value in bits 31:16. When low ≤ high, a character matches if low ≤ character ≤ high, bounds included.
- R2: When low > high, a character matches only if it equals the low value or the high value.
- R3: With `gate_mode` = 0, every character strobed in on `rx_valid` is presented on `fwd_valid`/`fwd_char` one cycle later, with the same data.
- R4: With `gate_mode` = 1 and the gate shut, non-matching characters are not forwarded. The first matching character is itself forwarded and opens the gate.
- R5: While the gate is open in hold mode, every character is forwarded, whether or not it matches. A control write (`ctl_wr`) with bit 12 of `ctl_data` set shuts the gate.
- R6: A clear request in the same cycle as a matching character in hold mode leaves the gate open. A control write with bit 12 clear has no effect on the gate.
- R7: `match_flag` is set one cycle after any matching character, in either mode. It stays set until a `stat_rd` strobe clears it. A match in the same cycle as the read keeps the flag set.
- R8: `irq_mask` is set by `irq_en_set` and cleared by `irq_en_clr`; set wins if both arrive together. `irq` equals `match_flag` AND `irq_mask`.
- R9: After reset the gate is shut, and `fwd_valid`, `match_flag`, `irq_mask` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | 16 | Received character |
| gate_mode | input | 1 | 0 = flag mode, 1 = hold mode |
| cmp_word | input | 32 | Compare values: low in 15:0, high in 31:16 |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 32 | Control word; bit 12 requests a gate clear |
| stat_rd | input | 1 | Status read strobe; clears the match flag |
| irq_en_set | input | 1 | Sets the interrupt enable |
| irq_en_clr | input | 1 | Clears the interrupt enable |
| fwd_valid | output | 1 | Forwarded-character strobe |
| fwd_char | output | 16 | Forwarded character |
| match_flag | output | 1 | Sticky match status |
| irq_mask | output | 1 | Interrupt enable state |
| irq | output | 1 | Masked match interrupt |

## Verification
The comparator is tried with characters at, just inside and just outside both window bounds. This separates an inclusive range test from an exclusive or off-by-one one. A reversed pair of compare values, with characters lying between them, separates range matching from equality matching.

Hold mode is driven through several sequences:
- non-matching characters while shut, to show they are dropped;
- a match, to show the trigger character itself is forwarded;
- non-matching characters while open, to show they pass;
- a clear coinciding with a match, and a control write without the clear bit.

Together these separate each transition of the gate. Random traffic from a small value set then mixes modes, reads, enable strobes and clears. Each cycle is compared against a reference model in the bench.

// File: rtl/rmg_pkg.sv
package rmg_pkg;
    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_PASS = 1'b1
    } gate_state_e;
endpackage

// File: rtl/rmg_compare.sv
module rmg_compare #(
    parameter int CHAR_W = 16
) (
    input  logic [CHAR_W-1:0]   ch,
    input  logic [2*CHAR_W-1:0] cmp_word,
    output logic                hit
);
    logic [CHAR_W-1:0] lo_val;
    logic [CHAR_W-1:0] hi_val;

    assign lo_val = cmp_word[CHAR_W-1:0];
    assign hi_val = cmp_word[2*CHAR_W-1:CHAR_W];

    always_comb begin
        if (lo_val <= hi_val) begin
            hit = (ch >= lo_val) && (ch <= hi_val);    // window test
        end else begin
            hit = (ch == lo_val) || (ch == hi_val);    // two-value test
        end
    end
endmodule

// File: rtl/rmg_gate_fsm.sv
module rmg_gate_fsm
    import rmg_pkg::*;
#(
    parameter int CHAR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              hit,
    input  logic              hold_mode,
    input  logic              clear_req,
    output logic              fwd_valid,
    output logic [CHAR_W-1:0] fwd_char
);
    gate_state_e state_q, state_d;
    logic        trigger;
    logic        pass_now;

    assign trigger = hold_mode && rx_valid && hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_SHUT;
        else        state_q <= state_d;
    end

    // Next state and forward decision
    always_comb begin
        state_d  = state_q;
        pass_now = 1'b0;
        unique case (state_q)
            GATE_SHUT: begin
                pass_now = rx_valid && (!hold_mode || hit);
                if (trigger) state_d = GATE_PASS;
            end
            GATE_PASS: begin
                pass_now = rx_valid;
                if (!trigger && clear_req) state_d = GATE_SHUT;
            end
            default: state_d = GATE_SHUT;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_char  <= '0;
        end else begin
            fwd_valid <= pass_now;
            if (pass_now) fwd_char <= rx_char;
        end
    end

    AST_SHUT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_SHUT && hold_mode && rx_valid && !hit) |=> !fwd_valid); // R4
    AST_TRIGGER_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (state_q == GATE_PASS && fwd_valid)); // R6
    AST_FREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_mode && rx_valid) |=> (fwd_valid && fwd_char == $past(rx_char))); // R3
    AST_RELEASE_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !trigger) |=> (state_q == GATE_SHUT)); // R5
endmodule

// File: rtl/rmg_flag_irq.sv
module rmg_flag_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_flag,
    input  logic stat_rd,
    input  logic en_set,
    input  logic en_clr,
    output logic flag,
    output logic mask,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            mask <= 1'b0;
        end else begin
            if (set_flag)     flag <= 1'b1;
            else if (stat_rd) flag <= 1'b0;
            if (en_set)       mask <= 1'b1;
            else if (en_clr)  mask <= 1'b0;
        end
    end

    assign irq = flag & mask;

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag |=> flag); // R7
    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !set_flag) |=> !flag); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_rd) |=> flag); // R7
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> mask); // R8
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr && !en_set) |=> !mask); // R8
endmodule

// File: rtl/rx_match_gate.sv
module rx_match_gate #(
    parameter int CHAR_W    = 16,
    parameter int CTL_W     = 32,
    parameter int CLEAR_BIT = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [CHAR_W-1:0]   rx_char,
    input  logic                gate_mode,
    input  logic [2*CHAR_W-1:0] cmp_word,
    input  logic                ctl_wr,
    input  logic [CTL_W-1:0]    ctl_data,
    input  logic                stat_rd,
    input  logic                irq_en_set,
    input  logic                irq_en_clr,
    output logic                fwd_valid,
    output logic [CHAR_W-1:0]   fwd_char,
    output logic                match_flag,
    output logic                irq_mask,
    output logic                irq
);
    logic hit;
    logic clear_req;

    assign clear_req = ctl_wr && ctl_data[CLEAR_BIT];

    rmg_compare #(.CHAR_W(CHAR_W)) u_cmp (
        .ch       (rx_char),
        .cmp_word (cmp_word),
        .hit      (hit)
    );

    rmg_gate_fsm #(.CHAR_W(CHAR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_char   (rx_char),
        .hit       (hit),
        .hold_mode (gate_mode),
        .clear_req (clear_req),
        .fwd_valid (fwd_valid),
        .fwd_char  (fwd_char)
    );

    rmg_flag_irq u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_flag (rx_valid && hit),
        .stat_rd  (stat_rd),
        .en_set   (irq_en_set),
        .en_clr   (irq_en_clr),
        .flag     (match_flag),
        .mask     (irq_mask),
        .irq      (irq)
    );

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_mask && match_flag)); // R8
endmodule

// File: tb/sim_rx_match_gate.sv
module sim_rx_match_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_char = '0;
    logic        gate_mode = 1'b0;
    logic [31:0] cmp_word = '0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_data = '0;
    logic        stat_rd = 1'b0;
    logic        irq_en_set = 1'b0;
    logic        irq_en_clr = 1'b0;
    logic        fwd_valid, match_flag, irq_mask, irq;
    logic [15:0] fwd_char;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit          m_open = 0, m_flag = 0, m_mask = 0, m_fv = 0;
    logic [15:0] m_fc = '0;
    string       fwd_tag = "R9";
    string       flag_tag = "R9";

    always #4 clk = ~clk; // 125 MHz

    rx_match_gate u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .gate_mode(gate_mode), .cmp_word(cmp_word), .ctl_wr(ctl_wr),
        .ctl_data(ctl_data), .stat_rd(stat_rd), .irq_en_set(irq_en_set),
        .irq_en_clr(irq_en_clr), .fwd_valid(fwd_valid), .fwd_char(fwd_char),
        .match_flag(match_flag), .irq_mask(irq_mask), .irq(irq)
    );

    function automatic bit ref_hit(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] lo = w[15:0];
        logic [15:0] hi = w[31:16];
        if (lo <= hi) return (c >= lo) && (c <= hi);
        return (c == lo) || (c == hi);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        check(fwd_tag, "fwd_valid", int'(fwd_valid), int'(m_fv));
        if (m_fv) check(fwd_tag, "fwd_char", int'(fwd_char), int'(m_fc));
        check(flag_tag, "match_flag", int'(match_flag), int'(m_flag));
        check("R8", "irq_mask", int'(irq_mask), int'(m_mask));
        check("R8", "irq", int'(irq), int'(m_flag & m_mask));
    endtask

    // Drive one cycle (called at a falling edge), update model, check after edge.
    task automatic step(input bit v, input logic [15:0] c, input bit mode,
                        input logic [31:0] w, input bit cwr, input logic [31:0] cd,
                        input bit rd, input bit es, input bit ec);
        bit h, clr;
        rx_valid = v; rx_char = c; gate_mode = mode; cmp_word = w;
        ctl_wr = cwr; ctl_data = cd; stat_rd = rd; irq_en_set = es; irq_en_clr = ec;
        h   = v && ref_hit(c, w);
        clr = cwr && cd[12];
        if (!mode)                    fwd_tag = "R3";
        else if (mode && h && clr)    fwd_tag = "R6";
        else if (m_open)              fwd_tag = "R5";
        else                          fwd_tag = "R4";
        flag_tag = (w[15:0] <= w[31:16]) ? "R1/R7" : "R2/R7";
        m_fv = v && (!mode || m_open || h);
        if (m_fv) m_fc = c;
        if (mode && h)  m_open = 1;
        else if (clr)   m_open = 0;
        if (h)          m_flag = 1;
        else if (rd)    m_flag = 0;
        if (es)         m_mask = 1;
        else if (ec)    m_mask = 0;
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic rx(input logic [15:0] c, input bit mode, input logic [31:0] w);
        step(1, c, mode, w, 0, 32'h0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] win  = {16'h0040, 16'h0020}; // lo 0x20, hi 0x40
        logic [31:0] pair = {16'h0010, 16'h0050}; // lo 0x50 > hi 0x10
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        fwd_tag = "R9"; flag_tag = "R9";
        check_outputs();                  // R9 reset state
        rst_n = 1'b1;
        @(negedge clk);

        // R1 window bounds in flag mode, R3 forwarding
        rx(16'h001F, 0, win);
        rx(16'h0020, 0, win);
        step(0, 16'h0, 0, win, 0, 0, 1, 0, 0);   // R7 read clears
        rx(16'h0040, 0, win);
        step(0, 16'h0, 0, win, 0, 0, 1, 0, 0);
        rx(16'h0041, 0, win);
        rx(16'h0030, 0, win);
        step(0, 16'h0, 0, win, 0, 0, 1, 0, 0);

        // R2 reversed pair: between values is no match
        rx(16'h0030, 0, pair);
        rx(16'h0010, 0, pair);
        step(0, 16'h0, 0, pair, 0, 0, 1, 0, 0);
        rx(16'h0050, 0, pair);
        step(1, 16'h0050, 0, pair, 0, 0, 1, 0, 0); // R7 match beats read

        // R8 enable and interrupt
        step(0, 16'h0, 0, win, 0, 0, 0, 1, 0);
        step(0, 16'h0, 0, win, 0, 0, 0, 1, 1);    // set wins
        step(0, 16'h0, 0, win, 0, 0, 1, 0, 0);
        step(0, 16'h0, 0, win, 0, 0, 0, 0, 1);

        // R4 hold mode: drops then trigger forwarded
        rx(16'h0001, 1, win);
        rx(16'h0077, 1, win);
        rx(16'h0025, 1, win);
        // R5 open passes non-matching
        rx(16'h0001, 1, win);
        rx(16'hFFFF, 1, win);
        // R6 control write without clear bit
        step(0, 16'h0, 1, win, 1, 32'hFFFF_EFFF, 0, 0, 0);
        rx(16'h0002, 1, win);
        // R6 clear with simultaneous match keeps open
        step(1, 16'h0021, 1, win, 1, 32'h0000_1000, 0, 0, 0);
        rx(16'h0003, 1, win);
        // R5 clear shuts
        step(0, 16'h0, 1, win, 1, 32'h0000_1000, 0, 0, 0);
        rx(16'h0004, 1, win);
        rx(16'h0040, 1, win);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a = 16'($urandom_range(0, 15));
            logic [15:0] b = 16'($urandom_range(0, 15));
            logic [31:0] w = {b, a};
            step($urandom_range(0, 3) != 0, 16'($urandom_range(0, 15)),
                 (i / 500) % 2 == 1, w,
                 $urandom_range(0, 9) == 0, $urandom_range(0, 1) ? 32'h1000 : 32'h0,
                 $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0,
                 $urandom_range(0, 15) == 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule